// File: doc/BRIEF.md
# Posted Write Buffer

The block sits between a processor core's store path and the memory system. Stores to regions that allow posting are taken in at once, so the pipeline keeps going while memory finishes the work later. Three kinds of store may be posted: writes to noncacheable bufferable regions, writes to write-through regions, and write misses to write-back regions. The buffer has sixteen word slots shared among four address entries. A store whose word address directly follows the last word of the newest entry is added to that entry. Entries leave in arrival order. Each leaves as a burst of consecutive words on a valid/ready memory port.

A store of the fourth kind, direct (non-bufferable), is never posted. It is held off until the buffer is completely empty. It then travels as a one-beat entry of its own, so it can never overtake older stores. Two commands force the buffer empty. A drain request stalls the core until every held word has reached memory, then answers with a one-cycle acknowledge. A wait-for-interrupt request drains in the same way, then places the block in a low-power state that holds the core off until a wake interrupt arrives.

Top module: `postwr_buf`

## Requirements
- R1: After reset, drained and coreReady are high, and memValid, drainAck and lowPower are low.
- R2: coreAttr encodes 0 = direct, 1 = noncacheable bufferable, 2 = write-through, 3 = write-back miss. A write with code 1, 2 or 3 is accepted in the cycle it is offered whenever space allows, even while memReady is held low.
- R3: A posted write whose word address equals the base plus length of the newest entry is added to that entry. This applies only when that entry is not the oldest one, which is the entry being presented to memory. Such a write needs no free address entry.
- R4: At most four address entries and sixteen words are held. A write that needs a new entry when four are held, or any write when sixteen words are held, sees coreReady low.
- R5: Entries go to memory strictly in arrival order. Each goes as a burst whose word address rises by one per beat, with data and byte strobes as written and memLast high only on the entry's final beat.
- R6: While memValid is high and memReady is low, memWordAddr, memData, memStrb and memLast hold their values.
- R7: A direct write (code 0) is accepted only when drained is high. It goes to memory as its own single-beat burst.
- R8: After drainReq, coreReady stays low until the buffer is empty. drainAck then pulses for exactly one cycle, with drained high in that cycle, and writes are accepted again afterwards.
- R9: After wfiReq, the buffer drains and lowPower rises. While lowPower is high, coreReady is low and no write is taken. lowPower falls in the cycle after wakeIrq is sampled high.
- R10: drained is high exactly when no entry is held and no beat is offered on the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| coreValid | input | 1 | Core offers a store |
| coreReady | output | 1 | Store is taken this cycle when coreValid is high |
| coreWordAddr | input | WADDR_W | Word address of the store |
| coreData | input | DATA_W | Store data |
| coreStrb | input | DATA_W/8 | Byte enables of the store |
| coreAttr | input | 2 | Region kind: 0 direct, 1 noncacheable bufferable, 2 write-through, 3 write-back miss |
| memValid | output | 1 | A beat is offered to memory |
| memReady | input | 1 | Memory takes the offered beat |
| memWordAddr | output | WADDR_W | Word address of the offered beat |
| memData | output | DATA_W | Data of the offered beat |
| memStrb | output | DATA_W/8 | Byte enables of the offered beat |
| memLast | output | 1 | Final beat of the current entry |
| drainReq | input | 1 | Request to empty the buffer |
| wfiReq | input | 1 | Request to empty the buffer and then sleep |
| wakeIrq | input | 1 | Interrupt that ends the low-power state |
| drainAck | output | 1 | One-cycle pulse when a requested drain completes |
| lowPower | output | 1 | Block is asleep after a wait-for-interrupt drain |
| drained | output | 1 | No entry held and no beat outstanding |

## Verification
The checker keeps its own count of held words. It adds one for every core handshake and removes one for every memory handshake. This count is correct only if a word moves only in a cycle where both valid and ready are high. It also relies on drainReq, wfiReq and wakeIrq being treated as plain sampled levels. The bench changes every input only on the falling clock edge. It offers the memory side three patterns: held off, always ready, and ready on alternate cycles. The two request lines are raised for a single cycle while the block is running, and wakeIrq only while it sleeps.

// File: rtl/postwr_buf_pkg.sv
package postwr_buf_pkg;

  typedef enum logic [1:0] {
    ATTR_DIRECT = 2'd0,
    ATTR_NCBUF  = 2'd1,
    ATTR_WTHRU  = 2'd2,
    ATTR_WBMISS = 2'd3
  } wrAttr_e;

  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_FLUSH     = 2'd1,
    ST_FLUSH_WFI = 2'd2,
    ST_SLEEP     = 2'd3
  } ctlState_e;

  typedef struct packed {
    logic pushWord;
    logic allocEntry;
    logic popBeat;
    logic popEntry;
  } bufCmd_t;

endpackage

// File: rtl/postwr_buf_data.sv
module postwr_buf_data
  import postwr_buf_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32,
  parameter int SLOTS   = 16,
  parameter int ENTRIES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bufCmd_t               cmd,
  input  logic [WADDR_W-1:0]    coreWordAddr,
  input  logic [DATA_W-1:0]     coreData,
  input  logic [DATA_W/8-1:0]   coreStrb,
  output logic [$clog2(ENTRIES+1)-1:0] entCnt,
  output logic [$clog2(SLOTS+1)-1:0]   slotCnt,
  output logic                  joinHit,
  output logic                  headLast,
  output logic [WADDR_W-1:0]    memWordAddr,
  output logic [DATA_W-1:0]     memData,
  output logic [DATA_W/8-1:0]   memStrb
);

  localparam int STRB_W  = DATA_W / 8;
  localparam int SLOT_IW = $clog2(SLOTS);
  localparam int ENT_IW  = $clog2(ENTRIES);
  localparam int SLOT_CW = $clog2(SLOTS + 1);
  localparam int ENT_CW  = $clog2(ENTRIES + 1);
  localparam int LEN_W   = SLOT_CW;

  // word slot ring
  logic [DATA_W-1:0]  slotData [SLOTS];
  logic [STRB_W-1:0]  slotStrb [SLOTS];
  logic [SLOT_IW-1:0] slotWr, slotRd;

  // address entry ring; words of an entry sit contiguously in the slot ring
  logic [WADDR_W-1:0] entBase [ENTRIES];
  logic [LEN_W-1:0]   entLen  [ENTRIES];
  logic [ENT_IW-1:0]  entHead, entTail, entNewest;
  logic [LEN_W-1:0]   beatIdx;

  assign entNewest = entTail - ENT_IW'(1);

  always_comb begin
    joinHit  = (entCnt >= ENT_CW'(2)) &&
               (coreWordAddr == entBase[entNewest] + WADDR_W'(entLen[entNewest]));
    headLast = (beatIdx == entLen[entHead] - LEN_W'(1));
    memWordAddr = entBase[entHead] + WADDR_W'(beatIdx);
    memData  = slotData[slotRd];
    memStrb  = slotStrb[slotRd];
  end

  always_ff @(posedge clk) begin
    if (cmd.pushWord) begin
      slotData[slotWr] <= coreData;
      slotStrb[slotWr] <= coreStrb;
    end
    if (cmd.allocEntry) begin
      entBase[entTail] <= coreWordAddr;
      entLen[entTail]  <= LEN_W'(1);
    end else if (cmd.pushWord) begin
      entLen[entNewest] <= entLen[entNewest] + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotWr  <= '0;
      slotRd  <= '0;
      slotCnt <= '0;
      entHead <= '0;
      entTail <= '0;
      entCnt  <= '0;
      beatIdx <= '0;
    end else begin
      if (cmd.pushWord)   slotWr  <= slotWr + SLOT_IW'(1);
      if (cmd.allocEntry) entTail <= entTail + ENT_IW'(1);
      slotCnt <= slotCnt + SLOT_CW'(cmd.pushWord) - SLOT_CW'(cmd.popBeat);
      entCnt  <= entCnt + ENT_CW'(cmd.allocEntry) - ENT_CW'(cmd.popEntry);
      if (cmd.popBeat) begin
        slotRd <= slotRd + SLOT_IW'(1);
        if (cmd.popEntry) begin
          beatIdx <= '0;
          entHead <= entHead + ENT_IW'(1);
        end else begin
          beatIdx <= beatIdx + LEN_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/postwr_buf_ctrl.sv
module postwr_buf_ctrl
  import postwr_buf_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int ENTRIES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         coreValid,
  input  logic [1:0]                   coreAttr,
  input  logic                         memReady,
  input  logic                         drainReq,
  input  logic                         wfiReq,
  input  logic                         wakeIrq,
  input  logic [$clog2(ENTRIES+1)-1:0] entCnt,
  input  logic [$clog2(SLOTS+1)-1:0]   slotCnt,
  input  logic                         joinHit,
  input  logic                         headLast,
  output bufCmd_t                      cmd,
  output logic                         coreReady,
  output logic                         memValid,
  output logic                         drainAck,
  output logic                         lowPower,
  output logic                         drained
);

  localparam int SLOT_CW = $clog2(SLOTS + 1);
  localparam int ENT_CW  = $clog2(ENTRIES + 1);

  ctlState_e state, stateNxt;
  logic bypass, empty, roomSlot, roomEnt, canTake, take;

  always_comb begin
    bypass   = (coreAttr == ATTR_DIRECT);
    empty    = (entCnt == '0);
    roomSlot = (slotCnt < SLOT_CW'(SLOTS));
    roomEnt  = (entCnt < ENT_CW'(ENTRIES));
    if (state != ST_RUN)  canTake = 1'b0;
    else if (bypass)      canTake = empty;
    else                  canTake = roomSlot && (joinHit || roomEnt);
    take           = coreValid && canTake;
    coreReady      = canTake;
    memValid       = !empty;
    drained        = empty;
    cmd.pushWord   = take;
    cmd.allocEntry = take && (bypass || !joinHit);
    cmd.popBeat    = memValid && memReady;
    cmd.popEntry   = cmd.popBeat && headLast;
    drainAck       = ((state == ST_FLUSH) || (state == ST_FLUSH_WFI)) && empty;
    lowPower       = (state == ST_SLEEP);
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN: begin
        if (wfiReq)        stateNxt = ST_FLUSH_WFI;
        else if (drainReq) stateNxt = ST_FLUSH;
      end
      ST_FLUSH:     if (empty)   stateNxt = ST_RUN;
      ST_FLUSH_WFI: if (empty)   stateNxt = ST_SLEEP;
      ST_SLEEP:     if (wakeIrq) stateNxt = ST_RUN;
      default:      stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/postwr_buf.sv
module postwr_buf
  import postwr_buf_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32,
  parameter int SLOTS   = 16,
  parameter int ENTRIES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                coreValid,
  output logic                coreReady,
  input  logic [WADDR_W-1:0]  coreWordAddr,
  input  logic [DATA_W-1:0]   coreData,
  input  logic [DATA_W/8-1:0] coreStrb,
  input  logic [1:0]          coreAttr,
  output logic                memValid,
  input  logic                memReady,
  output logic [WADDR_W-1:0]  memWordAddr,
  output logic [DATA_W-1:0]   memData,
  output logic [DATA_W/8-1:0] memStrb,
  output logic                memLast,
  input  logic                drainReq,
  input  logic                wfiReq,
  input  logic                wakeIrq,
  output logic                drainAck,
  output logic                lowPower,
  output logic                drained
);

  localparam int SLOT_CW = $clog2(SLOTS + 1);
  localparam int ENT_CW  = $clog2(ENTRIES + 1);

  bufCmd_t            cmd;
  logic [ENT_CW-1:0]  entCnt;
  logic [SLOT_CW-1:0] slotCnt;
  logic               joinHit, headLast, memValidInt;

  postwr_buf_ctrl #(.SLOTS(SLOTS), .ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rstN(rstN), .coreValid(coreValid), .coreAttr(coreAttr),
    .memReady(memReady), .drainReq(drainReq), .wfiReq(wfiReq), .wakeIrq(wakeIrq),
    .entCnt(entCnt), .slotCnt(slotCnt), .joinHit(joinHit), .headLast(headLast),
    .cmd(cmd), .coreReady(coreReady), .memValid(memValidInt), .drainAck(drainAck),
    .lowPower(lowPower), .drained(drained)
  );

  postwr_buf_data #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .ENTRIES(ENTRIES)) i_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .coreWordAddr(coreWordAddr),
    .coreData(coreData), .coreStrb(coreStrb), .entCnt(entCnt), .slotCnt(slotCnt),
    .joinHit(joinHit), .headLast(headLast), .memWordAddr(memWordAddr),
    .memData(memData), .memStrb(memStrb)
  );

  assign memValid = memValidInt;
  assign memLast  = memValidInt && headLast;

endmodule

// File: rtl/postwr_buf_chk.sv
module postwr_buf_chk #(
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32,
  parameter int SLOTS   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                coreValid,
  input logic                coreReady,
  input logic [1:0]          coreAttr,
  input logic                memValid,
  input logic                memReady,
  input logic [WADDR_W-1:0]  memWordAddr,
  input logic [DATA_W-1:0]   memData,
  input logic [DATA_W/8-1:0] memStrb,
  input logic                memLast,
  input logic                wakeIrq,
  input logic                drainAck,
  input logic                lowPower,
  input logic                drained
);

  localparam int CNT_W = $clog2(SLOTS + 1) + 1;
  logic [CNT_W-1:0] wordCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordCnt <= '0;
    else wordCnt <= wordCnt + CNT_W'(coreValid && coreReady) - CNT_W'(memValid && memReady);
  end

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady && !memLast |=> memValid && memWordAddr == $past(memWordAddr) + WADDR_W'(1)); // R5
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memWordAddr) && $stable(memData) && $stable(memStrb) && $stable(memLast)); // R6
  AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt == CNT_W'(SLOTS) |-> !coreReady); // R4
  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= CNT_W'(SLOTS)); // R4
  AST_DRAINED_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    drained |-> !memValid && wordCnt == '0); // R10
  AST_DIRECT_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    coreValid && coreReady && coreAttr == 2'd0 |-> drained); // R7
  AST_ACK_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    drainAck |-> drained); // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    drainAck |=> !drainAck); // R8
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    lowPower |-> !coreReady && drained); // R9
  AST_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    lowPower && wakeIrq |=> !lowPower); // R9

endmodule

bind postwr_buf postwr_buf_chk #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS)) i_postwrBufChk (
  .clk(clk), .rstN(rstN), .coreValid(coreValid), .coreReady(coreReady), .coreAttr(coreAttr),
  .memValid(memValid), .memReady(memReady), .memWordAddr(memWordAddr), .memData(memData),
  .memStrb(memStrb), .memLast(memLast), .wakeIrq(wakeIrq), .drainAck(drainAck),
  .lowPower(lowPower), .drained(drained)
);

// File: tb/test_postwr_buf.sv
module test_postwr_buf;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        coreValid = 1'b0;
  logic        coreReady;
  logic [29:0] coreWordAddr = '0;
  logic [31:0] coreData = '0;
  logic [3:0]  coreStrb = '0;
  logic [1:0]  coreAttr = 2'd1;
  logic        memValid, memReady, memLast;
  logic [29:0] memWordAddr;
  logic [31:0] memData;
  logic [3:0]  memStrb;
  logic        drainReq = 1'b0, wfiReq = 1'b0, wakeIrq = 1'b0;
  logic        drainAck, lowPower, drained;

  int memMode = 0;          // 0 hold off, 1 always ready, 2 alternate
  logic toggle = 1'b0;
  int checks = 0, errs = 0;

  logic [29:0] gotAddr [64]; logic [31:0] gotData [64]; logic [3:0] gotStrb [64]; logic gotLast [64];
  logic [29:0] expAddr [64]; logic [31:0] expData [64]; logic [3:0] expStrb [64]; logic expLast [64];
  int gotN = 0, expN = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) toggle <= ~toggle;
  assign memReady = (memMode == 1) || (memMode == 2 && toggle);

  postwr_buf i_postwr_buf (
    .clk(clk), .rstN(rstN), .coreValid(coreValid), .coreReady(coreReady),
    .coreWordAddr(coreWordAddr), .coreData(coreData), .coreStrb(coreStrb), .coreAttr(coreAttr),
    .memValid(memValid), .memReady(memReady), .memWordAddr(memWordAddr), .memData(memData),
    .memStrb(memStrb), .memLast(memLast), .drainReq(drainReq), .wfiReq(wfiReq),
    .wakeIrq(wakeIrq), .drainAck(drainAck), .lowPower(lowPower), .drained(drained)
  );

  always @(posedge clk) begin
    if (memValid && memReady && gotN < 64) begin
      gotAddr[gotN] = memWordAddr; gotData[gotN] = memData;
      gotStrb[gotN] = memStrb;     gotLast[gotN] = memLast;
      gotN++;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expBeat(input logic [29:0] a, input logic [31:0] d, input logic [3:0] s, input logic l);
    expAddr[expN] = a; expData[expN] = d; expStrb[expN] = s; expLast[expN] = l;
    expN++;
  endtask

  task automatic clearLog();
    @(negedge clk);
    gotN = 0; expN = 0;
  endtask

  task automatic compareLog(input string req);
    chk(req, "beat count", 64'(gotN), 64'(expN));
    for (int i = 0; i < expN && i < gotN; i++) begin
      chk(req, $sformatf("beat %0d addr", i), 64'(gotAddr[i]), 64'(expAddr[i]));
      chk(req, $sformatf("beat %0d data", i), 64'(gotData[i]), 64'(expData[i]));
      chk(req, $sformatf("beat %0d strb", i), 64'(gotStrb[i]), 64'(expStrb[i]));
      chk(req, $sformatf("beat %0d last", i), 64'(gotLast[i]), 64'(expLast[i]));
    end
  endtask

  task automatic wr(input logic [29:0] a, input logic [31:0] d, input logic [3:0] s,
                    input logic [1:0] at, input string req);
    bit acc = 1'b0;
    @(negedge clk);
    coreValid = 1'b1; coreWordAddr = a; coreData = d; coreStrb = s; coreAttr = at;
    for (int i = 0; i < 300 && !acc; i++) begin
      @(posedge clk);
      acc = coreReady;
    end
    @(negedge clk);
    coreValid = 1'b0;
    if (!acc) chk(req, "write accepted", 64'd0, 64'd1);
  endtask

  task automatic tryWr(input logic [29:0] a, input logic [1:0] at, output bit acc);
    @(negedge clk);
    coreValid = 1'b1; coreWordAddr = a; coreData = 32'hDEAD0000 | 32'(a); coreStrb = 4'hF; coreAttr = at;
    @(posedge clk);
    acc = coreReady;
    @(negedge clk);
    coreValid = 1'b0;
  endtask

  task automatic waitDrained(input string req);
    bit done = 1'b0;
    for (int i = 0; i < 500 && !done; i++) begin
      @(negedge clk);
      done = drained;
    end
    chk(req, "buffer drained", 64'(done), 64'd1);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", "drained", 64'(drained), 64'd1);
    chk("R1", "coreReady", 64'(coreReady), 64'd1);
    chk("R1", "memValid", 64'(memValid), 64'd0);
    chk("R1", "drainAck", 64'(drainAck), 64'd0);
    chk("R1", "lowPower", 64'(lowPower), 64'd0);
  endtask

  task automatic testJoinOrder();
    bit acc;
    clearLog(); memMode = 0;
    wr(30'h40, 32'h1111_0040, 4'hF, 2'd1, "R2");
    wr(30'h41, 32'h1111_0041, 4'h3, 2'd1, "R2");
    wr(30'h42, 32'h1111_0042, 4'hC, 2'd2, "R3");
    wr(30'h43, 32'h1111_0043, 4'hF, 2'd3, "R3");
    wr(30'h80, 32'h2222_0080, 4'h1, 2'd2, "R2");
    wr(30'hC0, 32'h3333_00C0, 4'hF, 2'd3, "R2");
    tryWr(30'h100, 2'd1, acc);
    chk("R4", "fifth entry stalled", 64'(acc), 64'd0);
    wr(30'hC1, 32'h3333_00C1, 4'h8, 2'd1, "R3");
    @(negedge clk);
    chk("R10", "drained while held", 64'(drained), 64'd0);
    chk("R5", "oldest entry presented", 64'(memWordAddr), 64'h40);
    expBeat(30'h40, 32'h1111_0040, 4'hF, 1'b1);
    expBeat(30'h41, 32'h1111_0041, 4'h3, 1'b0);
    expBeat(30'h42, 32'h1111_0042, 4'hC, 1'b0);
    expBeat(30'h43, 32'h1111_0043, 4'hF, 1'b1);
    expBeat(30'h80, 32'h2222_0080, 4'h1, 1'b1);
    expBeat(30'hC0, 32'h3333_00C0, 4'hF, 1'b0);
    expBeat(30'hC1, 32'h3333_00C1, 4'h8, 1'b1);
    memMode = 1;
    waitDrained("R10");
    compareLog("R5");
  endtask

  task automatic testSlotFull();
    bit acc;
    clearLog(); memMode = 0;
    for (int i = 0; i < 16; i++) begin
      wr(30'h1000 + 30'(i), 32'hAB00_0000 + 32'(i), 4'hF, 2'd1, "R4");
      expBeat(30'h1000 + 30'(i), 32'hAB00_0000 + 32'(i), 4'hF, (i == 0) || (i == 15));
    end
    tryWr(30'h1010, 2'd1, acc);
    chk("R4", "seventeenth word stalled", 64'(acc), 64'd0);
    memMode = 1;
    waitDrained("R4");
    compareLog("R4");
  endtask

  task automatic testBackpressure();
    logic [29:0] a0; logic [31:0] d0;
    clearLog(); memMode = 0;
    wr(30'h500, 32'h5500_0000, 4'hF, 2'd2, "R6");
    wr(30'h600, 32'h6600_0000, 4'h1, 2'd1, "R6");
    wr(30'h601, 32'h6600_0001, 4'h2, 2'd1, "R6");
    wr(30'h602, 32'h6600_0002, 4'h4, 2'd1, "R6");
    @(negedge clk);
    a0 = memWordAddr; d0 = memData;
    repeat (3) @(negedge clk);
    chk("R6", "address held", 64'(memWordAddr), 64'(a0));
    chk("R6", "data held", 64'(memData), 64'(d0));
    chk("R6", "valid held", 64'(memValid), 64'd1);
    expBeat(30'h500, 32'h5500_0000, 4'hF, 1'b1);
    expBeat(30'h600, 32'h6600_0000, 4'h1, 1'b0);
    expBeat(30'h601, 32'h6600_0001, 4'h2, 1'b0);
    expBeat(30'h602, 32'h6600_0002, 4'h4, 1'b1);
    memMode = 2;
    waitDrained("R6");
    compareLog("R5");
  endtask

  task automatic testDirect();
    bit acc;
    clearLog(); memMode = 0;
    wr(30'h200, 32'h7700_0200, 4'hF, 2'd1, "R7");
    tryWr(30'h300, 2'd0, acc);
    chk("R7", "direct write waits for drain", 64'(acc), 64'd0);
    memMode = 1;
    waitDrained("R7");
    memMode = 0;
    wr(30'h300, 32'h7700_0300, 4'h5, 2'd0, "R7");
    tryWr(30'h400, 2'd0, acc);
    chk("R7", "second direct write waits", 64'(acc), 64'd0);
    wr(30'h301, 32'h7700_0301, 4'hF, 2'd1, "R7");
    wr(30'h302, 32'h7700_0302, 4'hF, 2'd1, "R7");
    expBeat(30'h200, 32'h7700_0200, 4'hF, 1'b1);
    expBeat(30'h300, 32'h7700_0300, 4'h5, 1'b1);
    expBeat(30'h301, 32'h7700_0301, 4'hF, 1'b0);
    expBeat(30'h302, 32'h7700_0302, 4'hF, 1'b1);
    memMode = 1;
    waitDrained("R7");
    compareLog("R7");
  endtask

  task automatic testDrain();
    bit acc; int acks = 0; bit ackDrained = 1'b1;
    clearLog(); memMode = 0;
    wr(30'h700, 32'h8800_0700, 4'hF, 2'd1, "R8");
    wr(30'h800, 32'h8800_0800, 4'hF, 2'd2, "R8");
    @(negedge clk); drainReq = 1'b1;
    @(negedge clk); drainReq = 1'b0;
    tryWr(30'h900, 2'd1, acc);
    chk("R8", "core stalled during drain", 64'(acc), 64'd0);
    chk("R8", "no ack while held", 64'(drainAck), 64'd0);
    memMode = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (drainAck) begin
        acks++;
        ackDrained &= drained;
      end
    end
    chk("R8", "ack pulse count", 64'(acks), 64'd1);
    chk("R8", "drained at ack", 64'(ackDrained), 64'd1);
    tryWr(30'h900, 2'd1, acc);
    chk("R8", "write taken after drain", 64'(acc), 64'd1);
    waitDrained("R8");
  endtask

  task automatic testWfi();
    bit acc; bit slept = 1'b0;
    clearLog(); memMode = 0;
    wr(30'hA00, 32'h9900_0A00, 4'hF, 2'd3, "R9");
    @(negedge clk); wfiReq = 1'b1;
    @(negedge clk); wfiReq = 1'b0;
    chk("R9", "not asleep before drain", 64'(lowPower), 64'd0);
    memMode = 1;
    for (int i = 0; i < 50 && !slept; i++) begin
      @(negedge clk);
      slept = lowPower;
    end
    chk("R9", "low power reached", 64'(slept), 64'd1);
    chk("R9", "drained when asleep", 64'(drained), 64'd1);
    tryWr(30'hB00, 2'd1, acc);
    chk("R9", "write refused asleep", 64'(acc), 64'd0);
    @(negedge clk);
    chk("R9", "refused write not held", 64'(drained), 64'd1);
    chk("R9", "still asleep", 64'(lowPower), 64'd1);
    wakeIrq = 1'b1;
    @(negedge clk); wakeIrq = 1'b0;
    chk("R9", "awake after interrupt", 64'(lowPower), 64'd0);
    tryWr(30'hB00, 2'd1, acc);
    chk("R9", "write taken after wake", 64'(acc), 64'd1);
    waitDrained("R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R10 watchdog: actual %0d cycles expected completion", 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testJoinOrder();
    testSlotFull();
    testBackpressure();
    testDirect();
    testDrain();
    testWfi();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule